// File: doc/BRIEF.md
# Fetch-Block Branch Target Buffer

This block predicts where a taken branch will send the front end, before the fetched bytes are decoded. The fetch unit presents the address of a 16-byte fetch block. The block then searches one set of a 4-way set-associative array. That set holds partial-tag entries, one per remembered taken branch. Each entry records the branch's byte position inside its block and the branch's target. The exact branch address is unknown at fetch time. For that reason every entry in the set whose tag matches, and whose recorded position is at or past the fetch position, counts as a candidate. The candidate nearest the fetch position wins, because it is the first branch that fetch will reach.

The execute stage writes back through an update port. A resolved taken branch is written into the array, or refreshed if it is already there. Not-taken outcomes leave the array alone, so this buffer does not depend on any direction predictor. A partial tag can alias, so decode may find that a predicted branch is not a branch at all. The update port then reports that bogus prediction, and every way of the affected set is dropped. Inside a set, replacement follows least-recent use, tracked as a 2-bit age per way.

After reset, and after each flush, a small controller walks through the sets and clears one set per cycle. It has two states. In SWEEP, one set is cleared per cycle and both ports are ignored. The move SWEEP to READY happens when the last set has been cleared. A flush in READY moves the controller READY to SWEEP. A flush during SWEEP restarts the walk from set 0.

Top module: `btb_core`

## Requirements
- R1: From reset release, and from the cycle after a flush, the controller spends SETS cycles in SWEEP (512 by default). During SWEEP every lookup reports a miss and every update is ignored. When the walk ends, every entry is invalid.
- R2: Address fields are fixed by position: the byte offset in the block is ip[3:0], the set index is ip[12:4] and the partial tag is ip[21:13]. Bits ip[31:22] take no part in matching, so addresses that differ only there alias.
- R3: A lookup presented with lk_valid high in cycle t has its result on pred_hit, pred_target and pred_off in cycle t+1. pred_hit is low in any cycle that follows a cycle with lk_valid low.
- R4: A way is a candidate only if it is valid, its tag equals the lookup tag, and its stored offset is greater than or equal to the lookup offset. With no candidate the result is a miss.
- R5: When several ways are candidates, the one with the smallest stored offset wins. pred_target and pred_off come from that way.
- R6: An update with upd_taken=1 and upd_bogus=0 writes the branch (tag, offset, target) into the indexed set. An update with upd_taken=0 and upd_bogus=0 changes nothing.
- R7: A taken update whose tag and offset already sit in a valid way of the set overwrites that way's target and takes no second way.
- R8: A new branch goes into the lowest-numbered invalid way. If the set is full it replaces the least recently used way. Both a lookup hit and a write mark the way they touch as most recently used.
- R9: An update with upd_bogus=1 invalidates all four ways of the indexed set and leaves other sets unchanged.
- R10: When an update and a lookup reach the same set in the same cycle, the lookup sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Start a full invalidation walk |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_ip | input | 32 | Fetch address (block and byte offset) |
| upd_valid | input | 1 | Update request this cycle |
| upd_ip | input | 32 | Address of the resolved or bogus branch |
| upd_target | input | 32 | Resolved target to store |
| upd_taken | input | 1 | Branch resolved taken: write it |
| upd_bogus | input | 1 | Prediction hit a non-branch: clear the set |
| pred_hit | output | 1 | A predicted branch was found |
| pred_target | output | 32 | Predicted target |
| pred_off | output | 4 | Byte offset of the predicted branch |

## Verification
The hardest situation to reach from the ports is a full set in which eviction depends on recency, not on way number. The stimulus fills all four ways of one set and then touches every way with lookups in a chosen order. That fixes the age order whatever happened earlier. The next new branch must then displace the entry touched first. The stimulus also issues an update and a lookup to the same set in one cycle, to show that the lookup reads the contents from before the write.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_READY = 1'b1
    } btb_state_e;

endpackage

// File: rtl/btb_hit_sel.sv
module btb_hit_sel #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 9,
    parameter int OFF_W = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][OFF_W-1:0]  way_off,
    input  logic [TAG_W-1:0]            look_tag,
    input  logic [OFF_W-1:0]            look_off,
    output logic [WAYS-1:0]             cand,
    output logic                        any_hit,
    output logic [WAY_W-1:0]            win_way
);
    logic [OFF_W-1:0] best_off;

    for (genvar w = 0; w < WAYS; w++) begin : g_cand
        assign cand[w] = way_vld[w] && (way_tag[w] == look_tag) && (way_off[w] >= look_off);
    end

    always_comb begin
        any_hit  = 1'b0;
        win_way  = '0;
        best_off = '1;
        for (int w = 0; w < WAYS; w++) begin
            if (cand[w] && (!any_hit || way_off[w] < best_off)) begin
                any_hit  = 1'b1;
                win_way  = WAY_W'(w);
                best_off = way_off[w];
            end
        end
    end
endmodule

// File: rtl/btb_victim_pick.sv
module btb_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             way_vld,
    input  logic [WAYS-1:0][WAY_W-1:0]  way_age,
    output logic [WAY_W-1:0]            victim
);
    logic found_free;

    always_comb begin
        found_free = 1'b0;
        victim     = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!way_vld[w] && !found_free) begin
                found_free = 1'b1;
                victim     = WAY_W'(w);
            end
        end
        if (!found_free) begin
            for (int w = 0; w < WAYS; w++) begin
                if (way_age[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/btb_age_promote.sv
module btb_age_promote #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0]  age_in,
    input  logic [WAY_W-1:0]            touch,
    output logic [WAYS-1:0][WAY_W-1:0]  age_out
);
    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (WAY_W'(w) == touch)
                age_out[w] = '0;
            else if (age_in[w] < age_in[touch])
                age_out[w] = age_in[w] + 1'b1;
            else
                age_out[w] = age_in[w];
        end
    end
endmodule

// File: rtl/btb_core.sv
module btb_core
    import btb_pkg::*;
#(
    parameter int SETS  = 512,
    parameter int WAYS  = 4,
    parameter int TAG_W = 9,
    parameter int OFF_W = 4,
    parameter int IP_W  = 32,
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [IP_W-1:0]  lk_ip,
    input  logic             upd_valid,
    input  logic [IP_W-1:0]  upd_ip,
    input  logic [TGT_W-1:0] upd_target,
    input  logic             upd_taken,
    input  logic             upd_bogus,
    output logic             pred_hit,
    output logic [TGT_W-1:0] pred_target,
    output logic [OFF_W-1:0] pred_off
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_LO = OFF_W + IDX_W;
    localparam int TAG_HI = TAG_LO + TAG_W;

    // array state (RAM-like, cleared by the sweep walk)
    logic [WAYS-1:0]             vld_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
    logic [WAYS-1:0][OFF_W-1:0]  off_q [SETS];
    logic [WAYS-1:0][TGT_W-1:0]  tgt_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0]  age_q [SETS];

    btb_state_e       state_q, state_d;
    logic [IDX_W-1:0] ptr_q;

    function automatic logic [WAYS-1:0][WAY_W-1:0] fresh_ages();
        logic [WAYS-1:0][WAY_W-1:0] r;
        for (int w = 0; w < WAYS; w++) r[w] = WAY_W'(w);
        return r;
    endfunction

    // address fields
    logic [IDX_W-1:0] l_idx, u_idx;
    logic [TAG_W-1:0] l_tag, u_tag;
    logic [OFF_W-1:0] l_off, u_off;
    assign l_off = lk_ip[OFF_W-1:0];
    assign l_idx = lk_ip[OFF_W +: IDX_W];
    assign l_tag = lk_ip[TAG_LO +: TAG_W];
    assign u_off = upd_ip[OFF_W-1:0];
    assign u_idx = upd_ip[OFF_W +: IDX_W];
    assign u_tag = upd_ip[TAG_LO +: TAG_W];
    wire unused_ip_hi = ^{lk_ip[IP_W-1:TAG_HI], upd_ip[IP_W-1:TAG_HI]};

    logic lk_fire, upd_fire;
    assign lk_fire  = (state_q == ST_READY) && lk_valid;
    assign upd_fire = (state_q == ST_READY) && upd_valid;

    // lookup path
    logic [WAYS-1:0]  l_cand;
    logic             l_any;
    logic [WAY_W-1:0] l_way;
    logic [OFF_W-1:0] l_sel_off;

    btb_hit_sel #(.WAYS(WAYS), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_hit_sel (
        .way_vld  (vld_q[l_idx]),
        .way_tag  (tag_q[l_idx]),
        .way_off  (off_q[l_idx]),
        .look_tag (l_tag),
        .look_off (l_off),
        .cand     (l_cand),
        .any_hit  (l_any),
        .win_way  (l_way)
    );
    assign l_sel_off = off_q[l_idx][l_way];

    // update path
    logic             u_match;
    logic [WAY_W-1:0] m_way, v_way, alloc_way;
    logic [WAYS-1:0][WAY_W-1:0] u_age_nxt, l_age_nxt;

    always_comb begin
        u_match = 1'b0;
        m_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!u_match && vld_q[u_idx][w] && tag_q[u_idx][w] == u_tag
                && off_q[u_idx][w] == u_off) begin
                u_match = 1'b1;
                m_way   = WAY_W'(w);
            end
        end
    end

    btb_victim_pick #(.WAYS(WAYS)) u_victim (
        .way_vld (vld_q[u_idx]),
        .way_age (age_q[u_idx]),
        .victim  (v_way)
    );
    assign alloc_way = u_match ? m_way : v_way;

    btb_age_promote #(.WAYS(WAYS)) u_age_upd (
        .age_in  (age_q[u_idx]),
        .touch   (alloc_way),
        .age_out (u_age_nxt)
    );
    btb_age_promote #(.WAYS(WAYS)) u_age_look (
        .age_in  (age_q[l_idx]),
        .touch   (l_way),
        .age_out (l_age_nxt)
    );

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (flush)                   ptr_q <= '0;
            else if (state_q == ST_SWEEP) ptr_q <= ptr_q + 1'b1;
        end
    end

    // controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP: if (!flush && ptr_q == IDX_W'(SETS - 1)) state_d = ST_READY;
            ST_READY: if (flush) state_d = ST_SWEEP;
            default:  state_d = ST_SWEEP;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_hit    <= 1'b0;
            pred_target <= '0;
            pred_off    <= '0;
        end else begin
            pred_hit    <= lk_fire && l_any;
            pred_target <= tgt_q[l_idx][l_way];
            pred_off    <= l_sel_off;
        end
    end

    // array writes
    always_ff @(posedge clk) begin
        if (state_q == ST_SWEEP) begin
            vld_q[ptr_q] <= '0;
            age_q[ptr_q] <= fresh_ages();
        end else begin
            if (lk_fire && l_any && !(upd_fire && u_idx == l_idx))
                age_q[l_idx] <= l_age_nxt;
            if (upd_fire && upd_bogus) begin
                vld_q[u_idx] <= '0;
                age_q[u_idx] <= fresh_ages();
            end else if (upd_fire && upd_taken) begin
                tag_q[u_idx][alloc_way] <= u_tag;
                off_q[u_idx][alloc_way] <= u_off;
                tgt_q[u_idx][alloc_way] <= upd_target;
                vld_q[u_idx][alloc_way] <= 1'b1;
                age_q[u_idx]            <= u_age_nxt;
            end
        end
    end

    // assertions
    a_r3_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> $past(lk_valid));

    a_r4_off_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> pred_off >= $past(lk_ip[OFF_W-1:0]));

    a_r1_sweep_misses: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_SWEEP) |-> !pred_hit);

    a_r9_bogus_clears_set: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && upd_bogus) |=> vld_q[$past(u_idx)] == '0);

    for (genvar w = 0; w < WAYS; w++) begin : g_chk
        a_r5_lowest_offset: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_fire && l_cand[w]) |-> off_q[l_idx][w] >= l_sel_off);
    end
endmodule

// File: tb/btb_core_tb.sv
module btb_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_ip = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_ip = '0;
    logic [31:0] upd_target = '0;
    logic        upd_taken = 1'b0;
    logic        upd_bogus = 1'b0;
    logic        pred_hit;
    logic [31:0] pred_target;
    logic [3:0]  pred_off;

    int n_checks = 0;
    int n_fail   = 0;

    bit          exp_hit_q[$];
    logic [31:0] exp_tgt_q[$];
    logic [3:0]  exp_off_q[$];
    string       exp_req_q[$];

    always #2 clk = ~clk;

    btb_core u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_ip(lk_ip),
        .upd_valid(upd_valid), .upd_ip(upd_ip), .upd_target(upd_target),
        .upd_taken(upd_taken), .upd_bogus(upd_bogus),
        .pred_hit(pred_hit), .pred_target(pred_target), .pred_off(pred_off)
    );

    function automatic logic [31:0] mk_ip(input logic [9:0] hi, input logic [8:0] tag,
                                          input logic [8:0] idx, input logic [3:0] off);
        return {hi, tag, idx, off};
    endfunction

    task automatic check(input string req, input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver tasks: called at a falling edge, hold inputs for one cycle
    task automatic do_upd(input logic [31:0] ip, input logic [31:0] tgt,
                          input bit taken, input bit bogus);
        upd_valid = 1'b1; upd_ip = ip; upd_target = tgt;
        upd_taken = taken; upd_bogus = bogus;
        @(negedge clk);
        upd_valid = 1'b0; upd_taken = 1'b0; upd_bogus = 1'b0;
    endtask

    task automatic push_exp(input bit eh, input logic [31:0] et, input logic [3:0] eo,
                            input string req);
        exp_hit_q.push_back(eh);
        exp_tgt_q.push_back(et);
        exp_off_q.push_back(eo);
        exp_req_q.push_back(req);
    endtask

    task automatic do_look(input logic [31:0] ip, input bit eh, input logic [31:0] et,
                           input logic [3:0] eo, input string req);
        lk_valid = 1'b1; lk_ip = ip;
        push_exp(eh, et, eo, req);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic do_both(input logic [31:0] uip, input logic [31:0] tgt,
                           input logic [31:0] lip, input bit eh, input logic [31:0] et,
                           input logic [3:0] eo, input string req);
        upd_valid = 1'b1; upd_ip = uip; upd_target = tgt; upd_taken = 1'b1; upd_bogus = 1'b0;
        lk_valid = 1'b1; lk_ip = lip;
        push_exp(eh, et, eo, req);
        @(negedge clk);
        upd_valid = 1'b0; upd_taken = 1'b0; lk_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // monitor: compares the result one cycle after each lookup
    initial begin
        forever begin
            bit f;
            @(posedge clk);
            f = lk_valid;
            @(negedge clk);
            if (f) begin
                bit          eh;
                logic [31:0] et;
                logic [3:0]  eo;
                string       rq;
                eh = exp_hit_q.pop_front();
                et = exp_tgt_q.pop_front();
                eo = exp_off_q.pop_front();
                rq = exp_req_q.pop_front();
                check(rq, pred_hit == eh, "pred_hit", 32'(pred_hit), 32'(eh));
                if (eh) begin
                    check(rq, pred_target == et, "pred_target", pred_target, et);
                    check(rq, pred_off == eo, "pred_off", 32'(pred_off), 32'(eo));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", pred_hit == 1'b0, "pred_hit in reset", 32'(pred_hit), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: lookups miss and updates are ignored while sweeping
        do_look(mk_ip(0, 9'h40, 9'd0, 4'd0), 1'b0, 0, 0, "R1");
        do_upd(mk_ip(0, 9'h40, 9'd0, 4'd2), 32'hDEAD_0000, 1'b1, 1'b0);
        repeat (600) @(negedge clk);
        do_look(mk_ip(0, 9'h40, 9'd0, 4'd0), 1'b0, 0, 0, "R1");

        // R6/R2/R4: single allocation in set 5
        do_upd(mk_ip(0, 9'h12, 9'd5, 4'd6), 32'h0000_1000, 1'b1, 1'b0);
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd0), 1'b1, 32'h0000_1000, 4'd6, "R6");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd6), 1'b1, 32'h0000_1000, 4'd6, "R4");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd7), 1'b0, 0, 0, "R4");
        do_look(mk_ip(0, 9'h13, 9'd5, 4'd0), 1'b0, 0, 0, "R2");
        do_look(mk_ip(0, 9'h12, 9'd6, 4'd0), 1'b0, 0, 0, "R2");
        do_look(mk_ip(10'h2A5, 9'h12, 9'd5, 4'd1), 1'b1, 32'h0000_1000, 4'd6, "R2");
        @(negedge clk);
        check("R3", pred_hit == 1'b0, "pred_hit after idle cycle", 32'(pred_hit), 32'd0);

        // R5: several candidates in one set
        do_upd(mk_ip(0, 9'h12, 9'd5, 4'd3), 32'h0000_2000, 1'b1, 1'b0);
        do_upd(mk_ip(0, 9'h12, 9'd5, 4'd10), 32'h0000_3000, 1'b1, 1'b0);
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd0), 1'b1, 32'h0000_2000, 4'd3, "R5");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd4), 1'b1, 32'h0000_1000, 4'd6, "R5");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd8), 1'b1, 32'h0000_3000, 4'd10, "R5");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd11), 1'b0, 0, 0, "R4");

        // R6: not-taken update writes nothing
        do_upd(mk_ip(0, 9'h12, 9'd5, 4'd12), 32'h0000_4000, 1'b0, 1'b0);
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd11), 1'b0, 0, 0, "R6");

        // R7: refresh of an existing branch
        do_upd(mk_ip(0, 9'h12, 9'd5, 4'd6), 32'h0000_1111, 1'b1, 1'b0);
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd4), 1'b1, 32'h0000_1111, 4'd6, "R7");

        // R8: fourth branch fills the free way, keeping the other three
        do_upd(mk_ip(0, 9'h12, 9'd5, 4'd13), 32'h0000_5000, 1'b1, 1'b0);
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd12), 1'b1, 32'h0000_5000, 4'd13, "R8");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd9), 1'b1, 32'h0000_3000, 4'd10, "R8");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd5), 1'b1, 32'h0000_1111, 4'd6, "R7");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd1), 1'b1, 32'h0000_2000, 4'd3, "R8");
        // least recent is offset 13; a new branch must displace it
        do_upd(mk_ip(0, 9'h12, 9'd5, 4'd14), 32'h0000_6000, 1'b1, 1'b0);
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd11), 1'b1, 32'h0000_6000, 4'd14, "R8");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd9), 1'b1, 32'h0000_3000, 4'd10, "R8");

        // R10: same-cycle write and lookup on one set
        do_both(mk_ip(0, 9'h12, 9'd5, 4'd15), 32'h0000_7000,
                mk_ip(0, 9'h12, 9'd5, 4'd15), 1'b0, 0, 0, "R10");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd15), 1'b1, 32'h0000_7000, 4'd15, "R10");

        // R9: bogus report clears only the indexed set
        do_upd(mk_ip(0, 9'h21, 9'd6, 4'd2), 32'h0000_8000, 1'b1, 1'b0);
        do_upd(mk_ip(0, 9'h12, 9'd5, 4'd0), 32'h0, 1'b0, 1'b1);
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd0), 1'b0, 0, 0, "R9");
        do_look(mk_ip(0, 9'h12, 9'd5, 4'd12), 1'b0, 0, 0, "R9");
        do_look(mk_ip(0, 9'h21, 9'd6, 4'd0), 1'b1, 32'h0000_8000, 4'd2, "R9");

        // R1: flush invalidates everything
        do_upd(mk_ip(0, 9'h33, 9'd7, 4'd4), 32'h0000_9000, 1'b1, 1'b0);
        do_look(mk_ip(0, 9'h33, 9'd7, 4'd0), 1'b1, 32'h0000_9000, 4'd4, "R1");
        do_flush();
        do_look(mk_ip(0, 9'h33, 9'd7, 4'd0), 1'b0, 0, 0, "R1");
        repeat (600) @(negedge clk);
        do_look(mk_ip(0, 9'h33, 9'd7, 4'd0), 1'b0, 0, 0, "R1");
        do_look(mk_ip(0, 9'h21, 9'd6, 4'd0), 1'b0, 0, 0, "R1");

        repeat (3) @(negedge clk);
        check("R3", exp_hit_q.size() == 0, "pending results", 32'(exp_hit_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule